// File: doc/BRIEF.md
# Coherent 40-bit Timestamp Counter

This block keeps a free-running up-counter, 40 bits wide by default, that software reads through a 32-bit register port. The counter has no reload value and produces no interrupt. It advances by one on each clock cycle in which the external `tick` strobe is high and counting is enabled. A separate divider is expected to pace `tick`, nominally at about 983 kHz. That is faster than the 508 kHz reloading timers of the same subsystem.

The counter is wider than the bus, so a read of the low word also copies the counter's top byte into a shadow register. Both values are taken in the same cycle. A later read of the high register returns that byte together with the enable bit. Software reads low, then high, and always gets a 40-bit value without a tear. It does not matter how many ticks arrive between the two reads. The same high register also takes the enable bit on a write, which starts or freezes counting.

The port is a single-cycle strobe with a byte address. A read returns its data on `bus_rdata` one cycle after the strobe, and `bus_rdata` then holds until the next read.

Top module: `ts_stamp`

## Requirements
- R1: After a synchronous reset the count, the shadow byte and the enable are all zero, so reads of both registers return 0. While disabled, `tick` pulses leave the count unchanged.
- R2: While enabled, the count grows by exactly one for each cycle with `tick` high, and does not change in cycles with `tick` low.
- R3: A read at address 0x60 returns the count's low 32 bits, zero-extended, on `bus_rdata` one cycle after the strobe. It also stores the count's upper bits into the shadow.
- R4: A read at address 0x64 returns the shadow in bits 7:0 and the enable in bit 8, with bits 31:9 zero. The shadow changes only on a low-word read, so counting between two reads does not alter it.
- R5: A write at address 0x64 loads the enable from write-data bit 8 and ignores every other write-data bit. The write leaves the shadow and the count untouched.
- R6: Clearing the enable freezes the count at its current value without clearing it. Setting it again resumes counting from that value.
- R7: The count carries from the low word into the upper bits, and it wraps from all ones to zero.
- R8: A write to address 0x60, or a write to any address other than 0x60 and 0x64, changes no state. A read of any address other than 0x60 and 0x64 returns zero.
- R9: When a tick arrives in the same cycle as a low-word read, both the returned low word and the stored upper bits come from the count as it was before that tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Count strobe, one increment per high cycle while enabled |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read strobe, held until the next read |

## Verification
If the shadow byte goes wrong, it shows up on the very next high-register read. This stays hidden if only the low word is read, which is why the bench always reads both and adds ticks between the two reads. If the count goes wrong, a single low read shows it at once. A missed carry into the upper bits shows nothing until the count crosses a low-word boundary. To expose carry and wrap faults within a few thousand cycles, a second instance with narrow fields runs beside the full-width one. If the enable is lost, it shows up in bit 8 of the next high read. A frozen count that should have run, or a running count that should have been frozen, shows on the next low read.

// File: rtl/ts_pkg.sv
package ts_pkg;

    // Bit position of the count enable inside the high register.
    localparam int EN_BIT = 8;
    localparam int BUS_W  = 32;

    // Decoded kind of a single bus access.
    typedef enum logic [2:0] {
        ACC_IDLE,
        ACC_RD_LO,
        ACC_RD_HI,
        ACC_WR_HI,
        ACC_RD_OTHER,
        ACC_WR_DROP
    } acc_e;

    function automatic acc_e classify(input logic sel, input logic wr,
                                      input logic hit_lo, input logic hit_hi);
        acc_e k;
        if (!sel)
            k = ACC_IDLE;
        else if (wr)
            k = hit_hi ? ACC_WR_HI : ACC_WR_DROP;
        else if (hit_lo)
            k = ACC_RD_LO;
        else if (hit_hi)
            k = ACC_RD_HI;
        else
            k = ACC_RD_OTHER;
        return k;
    endfunction

endpackage

// File: rtl/ts_count.sv
module ts_count #(
    parameter int CW = 40
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          tick,
    output logic [CW-1:0] cnt
);

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (en && tick)
            cnt <= cnt + 1'b1;
    end

    AST_FROZEN_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(cnt)); // R6
    AST_IDLE_NO_STEP: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(cnt)); // R2
    AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (rst)
        (en && tick) |=> (cnt == CW'($past(cnt) + 1'b1))); // R7

endmodule

// File: rtl/ts_regs.sv
module ts_regs
    import ts_pkg::*;
#(
    parameter int             LO_W    = 32,
    parameter int             HI_W    = 8,
    parameter int             AW      = 8,
    parameter logic [AW-1:0]  LO_ADDR = 8'h60,
    parameter logic [AW-1:0]  HI_ADDR = 8'h64
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 sel,
    input  logic                 wr,
    input  logic [AW-1:0]        addr,
    input  logic [BUS_W-1:0]     wdata,
    input  logic [LO_W+HI_W-1:0] cnt,
    output logic                 en,
    output logic [BUS_W-1:0]     rdata
);

    localparam int CW = LO_W + HI_W;

    acc_e             acc;
    logic [HI_W-1:0]  shadow;
    logic [BUS_W-1:0] lo_word;
    logic [BUS_W-1:0] hi_word;
    logic             unused_wbits;

    assign acc          = classify(sel, wr, addr == LO_ADDR, addr == HI_ADDR);
    assign unused_wbits = ^{wdata[BUS_W-1:EN_BIT+1], wdata[EN_BIT-1:0]};

    always_comb begin
        lo_word               = '0;
        lo_word[LO_W-1:0]     = cnt[LO_W-1:0];
        hi_word               = '0;
        hi_word[HI_W-1:0]     = shadow;
        hi_word[EN_BIT]       = en;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en     <= 1'b0;
            shadow <= '0;
            rdata  <= '0;
        end else begin
            unique case (acc)
                ACC_RD_LO: begin
                    rdata  <= lo_word;
                    shadow <= cnt[CW-1:LO_W];
                end
                ACC_RD_HI:    rdata <= hi_word;
                ACC_RD_OTHER: rdata <= '0;
                ACC_WR_HI:    en    <= wdata[EN_BIT];
                default: ;
            endcase
        end
    end

    AST_SHADOW_HELD: assert property (@(posedge clk) disable iff (rst)
        (acc != ACC_RD_LO) |=> $stable(shadow)); // R4
    AST_LO_PRE_TICK: assert property (@(posedge clk) disable iff (rst)
        (acc == ACC_RD_LO) |=> (rdata[LO_W-1:0] == $past(cnt[LO_W-1:0]))); // R9
    AST_SHADOW_PRE_TICK: assert property (@(posedge clk) disable iff (rst)
        (acc == ACC_RD_LO) |=> (shadow == $past(cnt[CW-1:LO_W]))); // R3
    AST_HI_LAYOUT: assert property (@(posedge clk) disable iff (rst)
        (acc == ACC_RD_HI) |=> (rdata[BUS_W-1:EN_BIT+1] == '0
                                && rdata[EN_BIT] == $past(en)
                                && rdata[HI_W-1:0] == $past(shadow))); // R4
    AST_EN_FROM_BIT8: assert property (@(posedge clk) disable iff (rst)
        (acc == ACC_WR_HI) |=> (en == $past(wdata[EN_BIT]))); // R5
    AST_EN_ONLY_BY_WRITE: assert property (@(posedge clk) disable iff (rst)
        (acc != ACC_WR_HI) |=> $stable(en)); // R8

endmodule

// File: rtl/ts_stamp.sv
module ts_stamp #(
    parameter int            LO_W    = 32,
    parameter int            HI_W    = 8,
    parameter int            AW      = 8,
    parameter logic [AW-1:0] LO_ADDR = 8'h60,
    parameter logic [AW-1:0] HI_ADDR = 8'h64
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          bus_sel,
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    input  logic [31:0]   bus_wdata,
    output logic [31:0]   bus_rdata
);

    localparam int CW = LO_W + HI_W;

    logic [CW-1:0] cnt;
    logic          en;

    ts_count #(.CW(CW)) u_count (
        .clk  (clk),
        .rst  (rst),
        .en   (en),
        .tick (tick),
        .cnt  (cnt)
    );

    ts_regs #(
        .LO_W    (LO_W),
        .HI_W    (HI_W),
        .AW      (AW),
        .LO_ADDR (LO_ADDR),
        .HI_ADDR (HI_ADDR)
    ) u_regs (
        .clk   (clk),
        .rst   (rst),
        .sel   (bus_sel),
        .wr    (bus_wr),
        .addr  (bus_addr),
        .wdata (bus_wdata),
        .cnt   (cnt),
        .en    (en),
        .rdata (bus_rdata)
    );

endmodule

// File: tb/sim_ts_stamp.sv
module sim_ts_stamp;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] rd0, rd1;

    int checks = 0;
    int failures = 0;
    logic [39:0] exp_cnt = '0;
    logic        exp_en = 1'b0;

    always #5 clk = ~clk;

    // Full-width instance and a narrow twin (8 low + 4 high bits) for carry and wrap.
    ts_stamp u0 (.clk(clk), .rst(rst), .tick(tick), .bus_sel(bus_sel), .bus_wr(bus_wr),
                 .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rd0));
    ts_stamp #(.LO_W(8), .HI_W(4)) u1 (.clk(clk), .rst(rst), .tick(tick), .bus_sel(bus_sel),
                 .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rd1));

    localparam int NSTEP = 6;
    localparam int          STEP_TICKS [NSTEP] = '{1, 0, 5, 250, 3000, 1000};
    localparam logic [39:0] STEP_EXP   [NSTEP] = '{40'd1, 40'd1, 40'd6, 40'd256, 40'd3256, 40'd4256};

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic rd(input logic [7:0] a, input logic t, output logic [31:0] d0, output logic [31:0] d1);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a; tick = t;
        @(posedge clk); @(negedge clk);
        bus_sel = 1'b0; tick = 1'b0;
        if (t && exp_en) exp_cnt = exp_cnt + 1'b1;
        d0 = rd0; d1 = rd1;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
        if (a == 8'h64) exp_en = d[8];
    endtask

    task automatic ticks(input int n);
        if (n > 0) begin
            tick = 1'b1;
            repeat (n) @(negedge clk);
            tick = 1'b0;
            if (exp_en) exp_cnt = exp_cnt + 40'(n);
        end
    endtask

    function automatic logic [31:0] small_lo(input logic [39:0] c);
        return {24'd0, c[7:0]};
    endfunction

    function automatic logic [31:0] small_hi(input logic [39:0] c, input logic e);
        return {23'd0, e, 4'd0, c[11:8]};
    endfunction

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog got=running exp=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        logic [31:0] a0, a1;
        logic [39:0] latched;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset values, ticks ignored while disabled
        rd(8'h60, 1'b0, a0, a1); check("R1 lo after reset", a0, 32'h0);
        rd(8'h64, 1'b0, a0, a1); check("R1 hi after reset", a0, 32'h0);
        ticks(10);
        rd(8'h60, 1'b0, a0, a1); check("R1 ticks while disabled", a0, 32'h0);

        // R5: only bit 8 of the write matters
        wr(8'h64, 32'hFFFF_FFFF);
        rd(8'h64, 1'b0, a0, a1); check("R5 enable set, junk ignored", a0, 32'h100);
        wr(8'h64, 32'hFFFF_FEFF);
        rd(8'h64, 1'b0, a0, a1); check("R5 enable cleared", a0, 32'h0);
        wr(8'h64, 32'h0000_0100);

        // R2 R3 R7: table of tick bursts and expected cumulative counts
        for (int i = 0; i < NSTEP; i++) begin
            ticks(STEP_TICKS[i]);
            check("R2 bench model vs table", exp_cnt[31:0], STEP_EXP[i][31:0]);
            rd(8'h60, 1'b0, a0, a1);
            check("R3 lo word", a0, STEP_EXP[i][31:0]);
            check("R7 narrow lo carry/wrap", a1, small_lo(STEP_EXP[i]));
            rd(8'h64, 1'b0, a0, a1);
            check("R4 hi word", a0, {23'd0, 1'b1, STEP_EXP[i][39:32]});
            check("R7 narrow hi carry/wrap", a1, small_hi(STEP_EXP[i], 1'b1));
        end

        // R6: freeze and resume
        wr(8'h64, 32'h0);
        ticks(20);
        rd(8'h60, 1'b0, a0, a1); check("R6 frozen count held", a0, exp_cnt[31:0]);
        check("R6 frozen value is 4256", a0, 32'd4256);
        wr(8'h64, 32'h100);
        ticks(3);
        rd(8'h60, 1'b0, a0, a1); check("R6 resumed from held value", a0, 32'd4259);

        // R4: shadow stays put while counting between reads
        latched = exp_cnt;
        ticks(300);
        rd(8'h64, 1'b0, a0, a1); check("R4 shadow stable over ticks", a1, small_hi(latched, 1'b1));
        rd(8'h60, 1'b0, a0, a1); check("R3 lo after burst", a1, small_lo(exp_cnt));
        rd(8'h64, 1'b0, a0, a1); check("R3 new shadow latched", a1, small_hi(exp_cnt, 1'b1));

        // R8: ignored writes and unmapped reads
        wr(8'h60, 32'hDEAD_BEEF);
        wr(8'h68, 32'h0);
        rd(8'h60, 1'b0, a0, a1); check("R8 write to lo ignored", a0, exp_cnt[31:0]);
        rd(8'h64, 1'b0, a0, a1); check("R8 stray write kept enable", a0, 32'h100);
        rd(8'h68, 1'b0, a0, a1); check("R8 unmapped read is zero", a0, 32'h0);

        // R9: tick in the same cycle as the low read
        latched = exp_cnt;
        rd(8'h60, 1'b1, a0, a1); check("R9 lo from pre-tick count", a0, latched[31:0]);
        check("R9 narrow lo pre-tick", a1, small_lo(latched));
        rd(8'h60, 1'b0, a0, a1); check("R9 tick still counted", a0, exp_cnt[31:0]);

        // R1: reset mid-run
        @(negedge clk); rst = 1'b1; @(negedge clk); rst = 1'b0;
        exp_cnt = '0; exp_en = 1'b0;
        rd(8'h60, 1'b0, a0, a1); check("R1 lo after second reset", a0, 32'h0);
        rd(8'h64, 1'b0, a0, a1); check("R1 hi after second reset", a0, 32'h0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule